// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial core of a single-target SPI master. It accepts one word at a time from a transmit queue over a valid/ready handshake. It shifts that word out on MOSI while it toggles SCK, samples MISO on the selected edge, and returns exactly one received word per transmitted word over a second valid/ready handshake. Register decoding, queue storage and interrupt generation live outside the block. The block sees its settings as plain input levels and latches them at the start of every word.

The SPI mode is not a single polarity/phase pair. It comes from four separate controls: the capture edge, the idle clock level, a leading clock delay, and a frame-start selection that sets how long that delay lasts. The chip-select output is not sequenced by the engine. It follows a software-owned level input, so one frame can span several words.

The engine is a four-state machine. `ST_IDLE` holds SCK at the idle level and waits for a word. On the transition *accept* it goes to `ST_LEAD` when a delay is programmed, or straight to `ST_SHIFT` when none is. `ST_LEAD` holds SCK at idle for the delay and then takes the transition *lead done* to `ST_SHIFT`. `ST_SHIFT` toggles SCK once per half period, and after the final edge it takes *last edge* to `ST_TAIL`. `ST_TAIL` waits one half period and then takes *push* back to `ST_IDLE`, presenting the received word. Deasserting the enable is the *abort* transition: from any state it returns to `ST_IDLE` and pushes no word.

Top module: `spi_shift_engine`

## Requirements
- R1: One SCK half period lasts `ratio/2` system clocks. Bit 0 of `ratio` is ignored, and any value below 4 behaves as 4. Within a word, successive SCK edges are exactly one half period apart.
- R2: `cap_fall`=0 samples MISO on rising SCK edges and `cap_fall`=1 on falling edges. MOSI changes only on a non-sampling edge that follows a sampling edge. The first bit is driven when the word is accepted.
- R3: Outside a word, SCK equals `idle_high` (0 low, 1 high). The first SCK edge of every word moves away from that level.
- R4: The number of idle half periods before the first edge is D. D=0 when `clk_delay`=0. D=2 when `clk_delay`=1 and `start_fall`=0. D=1 when `clk_delay`=1 and `start_fall`=1. The first SCK edge comes (D+1) half periods after the accepting clock edge.
- R5: A word runs for `tx_len` SCK cycles (2×`tx_len` edges). A length field of 0 or above 32 means 32.
- R6: `fmt`=1 sends LSB first. Every other value sends MSB first, meaning bit (length−1) of the right-justified word goes out first.
- R7: The received word is right-justified. It keeps the first `rx_len` sampled bits (length coded as in R5), and all unused upper bits are zero. In MSB-first order the first sampled bit lands at position `rx_len`−1; in LSB-first order the k-th sampled bit lands at position k.
- R8: `cs_out` equals `frame_level` delayed by one clock. It is never changed by the shifting.
- R9: `tx_ready` is high only when `en` is high, the engine is idle and no received word is waiting. Clearing `en` abandons a word in progress: SCK returns to idle and no received word is produced.
- R10: Each accepted word yields exactly one received word. `rx_valid` and `rx_data` hold until `rx_ready`, and the next word is not accepted while a received word waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Engine enable; low aborts and blocks words |
| ratio | input | 8 | SCK divide ratio (even, 4..254) |
| cap_fall | input | 1 | Sampling edge: 0 rising, 1 falling |
| idle_high | input | 1 | SCK level between words |
| clk_delay | input | 1 | Insert idle half periods before the first edge |
| start_fall | input | 1 | Frame-start selection; picks delay length |
| frame_level | input | 1 | Software-driven chip-select level |
| tx_len | input | 6 | Transmit word length (1..32) |
| rx_len | input | 6 | Receive word length (1..32) |
| fmt | input | 2 | Bit order: 1 LSB first, others MSB first |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word taken this cycle |
| tx_data | input | 32 | Right-justified transmit word |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Received word consumed |
| rx_data | output | 32 | Right-justified received word |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_out | output | 1 | Chip-select / frame line |

## Verification
The assertions assume that `en`, `idle_high` and `frame_level` change only between clock edges, and that `rx_ready` is held while the bench expects a word to stay parked. The R9 and R3 properties also rely on `idle_high` being sampled as the idle level of the following cycle. For that reason the stimulus changes every input one nanosecond after a rising edge and never mid-cycle. Settings are changed only while the engine is idle, because the engine latches them at acceptance. The MISO source is either a loopback of MOSI or an edge-counting pattern updated on falling system-clock edges. Either source keeps MISO stable for at least one system clock before every sampling edge.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    localparam int WORD_W  = 32;
    localparam int LEN_W   = 6;
    localparam int RATIO_W = 8;
    localparam int HALF_W  = RATIO_W - 1;
    localparam int EDGE_W  = LEN_W + 1;
    localparam int IDX_W   = $clog2(WORD_W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TAIL
    } eng_state_t;

    typedef struct packed {
        logic [HALF_W-1:0] half;
        logic [1:0]        lead;
        logic [LEN_W-1:0]  txl;
        logic [LEN_W-1:0]  rxl;
        logic              lsb;
        logic              cap;
        logic              idle;
    } eng_cfg_t;

    function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] v);
        if (v == '0 || v > LEN_W'(WORD_W))
            return LEN_W'(WORD_W);
        return v;
    endfunction

    function automatic logic pick_bit(input logic [WORD_W-1:0] w,
                                      input logic [LEN_W-1:0]  len,
                                      input logic [LEN_W-1:0]  idx,
                                      input logic              lsb);
        logic [LEN_W-1:0] sel;
        sel = lsb ? idx : (len - idx - LEN_W'(1));
        return w[sel[IDX_W-1:0]];
    endfunction

endpackage

// File: rtl/spi_cfg_decode.sv
module spi_cfg_decode
    import spi_eng_pkg::*;
(
    input  logic [RATIO_W-1:0] ratio,
    input  logic               cap_fall,
    input  logic               idle_high,
    input  logic               clk_delay,
    input  logic               start_fall,
    input  logic [LEN_W-1:0]   tx_len,
    input  logic [LEN_W-1:0]   rx_len,
    input  logic [1:0]         fmt,
    output eng_cfg_t           cfg
);

    always_comb begin
        if (ratio < RATIO_W'(4))
            cfg.half = HALF_W'(2);
        else
            cfg.half = ratio[RATIO_W-1:1];

        if (!clk_delay)
            cfg.lead = 2'd0;
        else if (start_fall)
            cfg.lead = 2'd1;
        else
            cfg.lead = 2'd2;

        cfg.txl  = eff_len(tx_len);
        cfg.rxl  = eff_len(rx_len);
        cfg.lsb  = (fmt == 2'd1);
        cfg.cap  = cap_fall;
        cfg.idle = idle_high;
    end

endmodule

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] half,
    output logic         tick
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load || cnt_q == '0)
            cnt_q <= half - W'(1);
        else
            cnt_q <= cnt_q - W'(1);
    end

    assign tick = !load && (cnt_q == '0);

endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift
    import spi_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              take,
    input  logic              bit_in,
    input  logic [LEN_W-1:0]  idx,
    input  logic [LEN_W-1:0]  rxl,
    input  logic              lsb,
    output logic [WORD_W-1:0] word
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            word <= '0;
        else if (clear)
            word <= '0;
        else if (take && idx < rxl) begin
            if (lsb)
                word[idx[IDX_W-1:0]] <= bit_in;
            else
                word <= {word[WORD_W-2:0], bit_in};
        end
    end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_eng_pkg::*;
#(
    parameter logic CS_RESET = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               cap_fall,
    input  logic               idle_high,
    input  logic               clk_delay,
    input  logic               start_fall,
    input  logic               frame_level,
    input  logic [LEN_W-1:0]   tx_len,
    input  logic [LEN_W-1:0]   rx_len,
    input  logic [1:0]         fmt,
    input  logic               tx_valid,
    output logic               tx_ready,
    input  logic [WORD_W-1:0]  tx_data,
    output logic               rx_valid,
    input  logic               rx_ready,
    output logic [WORD_W-1:0]  rx_data,
    output logic               sck,
    output logic               mosi,
    input  logic               miso,
    output logic               cs_out
);

    eng_state_t state_q, state_d;
    eng_cfg_t   cfg_in, cfg_q;

    logic [EDGE_W-1:0] edge_q;
    logic [LEN_W-1:0]  kcap_q;
    logic [1:0]        lead_q;
    logic [WORD_W-1:0] txw_q;
    logic [WORD_W-1:0] rx_word;
    logic [HALF_W-1:0] timer_half;
    logic              sck_q, mosi_q, rx_valid_q, cs_q;
    logic              tick, accept, sck_nx, cap_edge, last_edge, take;

    spi_cfg_decode u_dec (
        .ratio      (ratio),
        .cap_fall   (cap_fall),
        .idle_high  (idle_high),
        .clk_delay  (clk_delay),
        .start_fall (start_fall),
        .tx_len     (tx_len),
        .rx_len     (rx_len),
        .fmt        (fmt),
        .cfg        (cfg_in)
    );

    assign timer_half = (state_q == ST_IDLE) ? cfg_in.half : cfg_q.half;

    spi_half_timer #(.W(HALF_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (state_q == ST_IDLE),
        .half  (timer_half),
        .tick  (tick)
    );

    assign tx_ready  = (state_q == ST_IDLE) && en && !rx_valid_q;
    assign accept    = tx_ready && tx_valid;
    assign sck_nx    = ~sck_q;
    assign cap_edge  = (sck_nx == ~cfg_q.cap);
    assign last_edge = ((edge_q + EDGE_W'(1)) == {cfg_q.txl, 1'b0});
    assign take      = (state_q == ST_SHIFT) && tick && cap_edge;

    spi_rx_shift u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .take   (take),
        .bit_in (miso),
        .idx    (kcap_q),
        .rxl    (cfg_q.rxl),
        .lsb    (cfg_q.lsb),
        .word   (rx_word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)
                          state_d = (cfg_in.lead != 2'd0) ? ST_LEAD : ST_SHIFT;
            ST_LEAD:  if (tick && (lead_q + 2'd1) == cfg_q.lead)
                          state_d = ST_SHIFT;
            ST_SHIFT: if (tick && last_edge)
                          state_d = ST_TAIL;
            ST_TAIL:  if (tick)
                          state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
        if (!en)
            state_d = ST_IDLE;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            edge_q     <= '0;
            kcap_q     <= '0;
            lead_q     <= '0;
            txw_q      <= '0;
            sck_q      <= 1'b0;
            mosi_q     <= 1'b0;
            rx_valid_q <= 1'b0;
            rx_data    <= '0;
            cs_q       <= CS_RESET;
        end else begin
            cs_q <= frame_level;
            if (rx_valid_q && rx_ready)
                rx_valid_q <= 1'b0;
            if (!en) begin
                sck_q <= idle_high;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        sck_q <= idle_high;
                        if (accept) begin
                            cfg_q  <= cfg_in;
                            txw_q  <= tx_data;
                            edge_q <= '0;
                            kcap_q <= '0;
                            lead_q <= '0;
                            mosi_q <= pick_bit(tx_data, cfg_in.txl, '0, cfg_in.lsb);
                        end
                    end
                    ST_LEAD: begin
                        sck_q <= cfg_q.idle;
                        if (tick)
                            lead_q <= lead_q + 2'd1;
                    end
                    ST_SHIFT: begin
                        if (tick) begin
                            sck_q  <= sck_nx;
                            edge_q <= edge_q + EDGE_W'(1);
                            if (cap_edge)
                                kcap_q <= kcap_q + LEN_W'(1);
                            else if (kcap_q != '0 && kcap_q < cfg_q.txl)
                                mosi_q <= pick_bit(txw_q, cfg_q.txl, kcap_q, cfg_q.lsb);
                        end
                    end
                    ST_TAIL: begin
                        if (tick) begin
                            rx_valid_q <= 1'b1;
                            rx_data    <= rx_word;
                        end
                    end
                    default: sck_q <= idle_high;
                endcase
            end
        end
    end

    assign sck      = sck_q;
    assign mosi     = mosi_q;
    assign rx_valid = rx_valid_q;
    assign cs_out   = cs_q;

endmodule

// File: rtl/spi_engine_checker.sv
module spi_engine_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        en,
    input logic        idle_high,
    input logic        frame_level,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic        rx_valid,
    input logic        rx_ready,
    input logic [31:0] rx_data,
    input logic        sck,
    input logic        cs_out
);

    p_ready_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (en && !rx_valid));

    p_rx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    p_one_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    p_idle_sck_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (sck == $past(idle_high)));

    p_cs_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cs_out == $past(frame_level)));

endmodule

bind spi_shift_engine spi_engine_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .idle_high   (idle_high),
    .frame_level (frame_level),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready),
    .rx_data     (rx_data),
    .sck         (sck),
    .cs_out      (cs_out)
);

// File: tb/tb_spi_shift_engine.sv
`timescale 1ns/1ps
module tb_spi_shift_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [7:0]  ratio = 8'd4;
    logic        cap_fall = 1'b0, idle_high = 1'b0, clk_delay = 1'b0, start_fall = 1'b0;
    logic        frame_level = 1'b1;
    logic [5:0]  tx_len = 6'd8, rx_len = 6'd8;
    logic [1:0]  fmt = 2'd0;
    logic        tx_valid = 1'b0, rx_ready = 1'b1;
    logic [31:0] tx_data = '0;
    logic        tx_ready, rx_valid, sck, mosi, miso, cs_out;
    logic [31:0] rx_data;
    logic        loop_mode = 1'b1;
    logic        pat = 1'b0;

    int errors = 0, checks = 0;
    int cyc = 0, acc_cyc = 0, acc_cnt = 0, pop_cnt = 0;
    int tgl_cnt = 0, first_cyc = 0, last_cyc = 0, bad_int = 0, exp_h = 2;
    logic sck_prev = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign miso = loop_mode ? mosi : pat;

    spi_shift_engine dut (
        .clk(clk), .rst_n(rst_n), .en(en), .ratio(ratio), .cap_fall(cap_fall),
        .idle_high(idle_high), .clk_delay(clk_delay), .start_fall(start_fall),
        .frame_level(frame_level), .tx_len(tx_len), .rx_len(rx_len), .fmt(fmt),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_out(cs_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // monitor: SCK edges, acceptance, MISO pattern, scoreboard
    always @(negedge clk) begin
        logic [31:0] e;
        string t;
        if (sck != sck_prev) begin
            if (tgl_cnt == 0) first_cyc = cyc;
            else if (cyc - last_cyc != exp_h) bad_int++;
            last_cyc = cyc;
            tgl_cnt++;
        end
        sck_prev = sck;
        if (tx_valid && tx_ready) begin
            acc_cyc = cyc;
            tgl_cnt = 0;
            bad_int = 0;
            acc_cnt++;
        end
        pat = tgl_cnt[0];
        if (rx_valid && rx_ready) begin
            if (exp_q.size() == 0)
                chk(1'b0, "R10", "unexpected rx word", rx_data, 0);
            else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rx_data == e, t, "rx word", rx_data, e);
            end
            pop_cnt++;
        end
    end

    task automatic setcfg(input int r, input bit cp, input bit idl, input bit dly,
                          input bit st, input int tl, input int rl, input int f);
        ratio = 8'(r); cap_fall = cp; idle_high = idl; clk_delay = dly; start_fall = st;
        tx_len = 6'(tl); rx_len = 6'(rl); fmt = 2'(f);
        exp_h = (r < 4) ? 2 : r / 2;
        step(2);
    endtask

    task automatic xfer(input logic [31:0] d, input logic [31:0] e, input int edges,
                        input int first, input string tag);
        int n0, p0;
        exp_q.push_back(e); tag_q.push_back(tag);
        n0 = acc_cnt; p0 = pop_cnt;
        tx_data = d; tx_valid = 1'b1;
        wait (acc_cnt != n0);
        @(posedge clk); #1 tx_valid = 1'b0;
        wait (pop_cnt != p0);
        step(2);
        chk(tgl_cnt == edges, tag, "sck edge count", tgl_cnt, edges);
        chk(first_cyc - acc_cyc - 1 == first, "R4", "first edge latency", first_cyc - acc_cyc - 1, first);
        chk(bad_int == 0, "R1", "half-period spacing errors", bad_int, 0);
        chk(sck == idle_high, "R3", "sck idle after word", sck, idle_high);
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        report();
    end

    initial begin
        int n0, p0;
        step(3);
        rst_n = 1'b1;
        step(2);
        chk(sck == 1'b0, "R3", "reset sck idle", sck, 0);
        chk(rx_valid == 1'b0, "R10", "reset rx_valid", rx_valid, 0);
        chk(tx_ready == 1'b0, "R9", "tx_ready with en low", tx_ready, 0);
        chk(cs_out == 1'b1, "R8", "cs follows level", cs_out, 1);

        en = 1'b1;
        // R1/R5 basic MSB loopback
        setcfg(4, 0, 0, 0, 0, 8, 8, 0);
        xfer(32'h1A5, 32'hA5, 16, 2, "R5");
        // R6 LSB first, full loopback
        setcfg(4, 0, 0, 0, 0, 12, 12, 1);
        xfer(32'hF3C96, 32'hC96, 24, 2, "R6");
        // R6/R7 order shown by truncated receive
        setcfg(4, 0, 0, 0, 0, 8, 4, 0);
        xfer(32'hB6, 32'hB, 16, 2, "R7");
        setcfg(4, 0, 0, 0, 0, 8, 4, 1);
        xfer(32'hB6, 32'h6, 16, 2, "R6");
        setcfg(4, 0, 0, 0, 0, 8, 4, 2);
        xfer(32'hB6, 32'hB, 16, 2, "R6");
        // R5 length coding
        setcfg(4, 1, 1, 0, 0, 0, 0, 0);
        xfer(32'hDEADBEEF, 32'hDEADBEEF, 64, 2, "R5");
        setcfg(4, 0, 0, 0, 0, 40, 40, 1);
        xfer(32'h8001_0002, 32'h8001_0002, 64, 2, "R5");
        setcfg(4, 0, 0, 0, 0, 1, 1, 0);
        xfer(32'hFFFF_FFFF, 32'h1, 2, 2, "R5");
        // R4 delay lengths (H=5)
        setcfg(10, 0, 0, 1, 0, 4, 4, 0);
        xfer(32'h9, 32'h9, 8, 15, "R4");
        setcfg(10, 0, 0, 1, 1, 4, 4, 0);
        xfer(32'h6, 32'h6, 8, 10, "R4");
        setcfg(10, 0, 0, 0, 1, 4, 4, 0);
        xfer(32'h5, 32'h5, 8, 5, "R4");
        // R1 ratio coding
        setcfg(9, 0, 0, 0, 0, 4, 4, 0);
        xfer(32'hA, 32'hA, 8, 4, "R1");
        setcfg(2, 0, 0, 0, 0, 4, 4, 0);
        xfer(32'h3, 32'h3, 8, 2, "R1");
        setcfg(254, 0, 0, 0, 0, 1, 1, 0);
        xfer(32'h0, 32'h0, 2, 127, "R1");
        // R2/R3 sampling edge with an edge-counting MISO pattern
        loop_mode = 1'b0;
        setcfg(4, 0, 0, 0, 0, 8, 8, 0);
        xfer(32'h0, 32'h00, 16, 2, "R2");
        setcfg(4, 1, 0, 0, 0, 8, 8, 0);
        xfer(32'h0, 32'hFF, 16, 2, "R2");
        setcfg(4, 1, 1, 0, 0, 8, 8, 0);
        chk(sck == 1'b1, "R3", "sck follows idle level", sck, 1);
        xfer(32'h0, 32'h00, 16, 2, "R2");
        setcfg(4, 0, 1, 1, 1, 8, 8, 1);
        xfer(32'h0, 32'hFF, 16, 4, "R2");
        loop_mode = 1'b1;
        // R8 chip select
        frame_level = 1'b0; step(1);
        chk(cs_out == 1'b0, "R8", "cs low after one clock", cs_out, 0);
        frame_level = 1'b1; step(1);
        chk(cs_out == 1'b1, "R8", "cs high after one clock", cs_out, 1);
        // R9 abort
        setcfg(10, 0, 0, 0, 0, 16, 16, 0);
        n0 = acc_cnt; tx_data = 32'h1234; tx_valid = 1'b1;
        wait (acc_cnt != n0);
        @(posedge clk); #1 tx_valid = 1'b0;
        step(20);
        en = 1'b0;
        step(2);
        chk(sck == idle_high, "R9", "sck idle after abort", sck, idle_high);
        chk(tx_ready == 1'b0, "R9", "tx_ready low while disabled", tx_ready, 0);
        step(200);
        chk(rx_valid == 1'b0, "R9", "no rx word after abort", rx_valid, 0);
        en = 1'b1;
        setcfg(4, 0, 0, 0, 0, 8, 8, 0);
        xfer(32'h3C, 32'h3C, 16, 2, "R9");
        // R10 back-pressure
        rx_ready = 1'b0;
        exp_q.push_back(32'h5A); tag_q.push_back("R10");
        exp_q.push_back(32'hC3); tag_q.push_back("R10");
        p0 = pop_cnt;
        n0 = acc_cnt; tx_data = 32'h5A; tx_valid = 1'b1;
        wait (acc_cnt != n0);
        @(posedge clk); #1 tx_data = 32'hC3;
        wait (rx_valid == 1'b1);
        step(5);
        chk(rx_valid == 1'b1, "R10", "rx_valid held", rx_valid, 1);
        chk(rx_data == 32'h5A, "R10", "rx_data held", rx_data, 32'h5A);
        chk(tx_ready == 1'b0, "R10", "next word blocked", tx_ready, 0);
        n0 = acc_cnt;
        rx_ready = 1'b1;
        wait (acc_cnt != n0);
        @(posedge clk); #1 tx_valid = 1'b0;
        wait (pop_cnt == p0 + 2);
        step(4);
        chk(pop_cnt == p0 + 2, "R10", "one rx per tx", pop_cnt - p0, 2);
        report();
    end

endmodule